// File: doc/BRIEF.md
# Module Slot Access Watchdog and Status Register

This block sits between a host-side access engine and four plug-in module slots. Each host access to a slot is announced with a start pulse. From then on the block counts clock cycles until the module answers with its acknowledge. If the answer arrives inside the window, the block completes the access toward the host with the module's data. If the window runs out first, the block ends the access on its own. The host then sees an ordinary completion whose read data is all ones, and the only trace of the failure is a sticky per-slot flag.

The same block owns a status word covering all four slots. The word holds eight interrupt-status bits (two lines per slot), the four timeout flags and the live state of each slot's active-low error input. Interrupt and error inputs are synchronized through two flops before they are used. Each interrupt line is either level-sensitive or edge-capturing, as chosen by a per-line mode input. Timeout flags and captured edges are cleared by writing ones. A per-slot enable input lets a timeout flag drive a single interrupt request output.

Top module: `mbt_top`

## Requirements
- R1: If the module asserts modAck in any of the TIMEOUT_CYCLES cycles that follow the cycle in which accStart was sampled, hostDone pulses high for exactly one cycle, in the cycle after the acknowledge was sampled, and hostRdata holds the modRdata sampled with the acknowledge.
- R2: If no acknowledge is sampled in those TIMEOUT_CYCLES cycles, hostDone pulses for one cycle TIMEOUT_CYCLES cycles after the start was sampled. hostRdata is then all ones, and the timeout flag of the accessed slot (statusOut bit 8 + slot) becomes 1. An acknowledge in the last cycle of the window still counts as in time.
- R3: A start sampled while an access is still open abandons that access without a completion pulse and restarts the window for the new slot.
- R4: Writing with regWe high clears every timeout flag whose regWdata bit (8 + slot) is 1. Bits written as 0 leave the flags unchanged. A timeout that sets a flag in the same cycle as a clear of that flag leaves the flag set.
- R5: irqReq is high exactly when some slot has both its timeout flag and its toutEn bit set.
- R6: statusOut bits 15..12 show the inverse of slotErrN (bit 12 + slot) two cycles after the input, with no latching.
- R7: A line n with edgeMode[n]=1 sets statusOut bit n three cycles after slotIrqN[n] falls, keeps it after the line returns high, and clears it when written with regWdata bit n = 1.
- R8: A line n with edgeMode[n]=0 shows the inverse of slotIrqN[n] in statusOut bit n three cycles later, and writes to bit n have no effect.
- R9: For an edge-mode line, a new activation in the same cycle as a clear write for that bit leaves the bit set.
- R10: After reset, with all inputs inactive, hostDone is 0, statusOut is all zeros and irqReq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accStart | input | 1 | One-cycle pulse opening an access |
| accSlot | input | 2 | Slot index of the access being opened |
| modAck | input | 1 | Acknowledge from the module of the open access |
| modRdata | input | DATA_W | Read data from the module, taken with modAck |
| hostDone | output | 1 | One-cycle completion pulse toward the host |
| hostRdata | output | DATA_W | Completion data; all ones after a timeout |
| regWe | input | 1 | Write strobe for the status word |
| regWdata | input | 12 | Write-1-to-clear data: bits 7..0 interrupt lines, bits 11..8 timeout flags |
| statusOut | output | 16 | Status word: 7..0 interrupt status, 11..8 timeout flags, 15..12 error state |
| toutEn | input | 4 | Per-slot timeout interrupt enable |
| edgeMode | input | 8 | Per-line mode: 1 edge-capturing, 0 level-sensitive |
| slotIrqN | input | 8 | Interrupt lines, active low, two per slot |
| slotErrN | input | 4 | Error lines, active low, one per slot |
| irqReq | output | 1 | Timeout interrupt request |

## Verification
The hardest situations to reach from the ports both need same-cycle collisions. In one, a clear write meets a timeout expiring on the very slot it clears. In the other, it meets an edge-mode line activating in the cycle its bit is written. The bench reaches the first by opening an access that is never acknowledged and driving the clear in the last cycle of the window. It reaches the second by counting the synchronizer depth exactly so that the write lands in the cycle after the activation passes the second flop. The window boundary, an acknowledge in the last in-time cycle against one a cycle later, is driven directly. Randomized acknowledge delays then spread across both sides of it.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  // Number of module slots and the width of a slot index.
  localparam int unsigned MBT_SLOTS  = 4;
  localparam int unsigned MBT_SLOT_W = $clog2(MBT_SLOTS);

  // Access watchdog state.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } mbtState_t;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic                  ackTake;   // open access acknowledged in time
    logic                  toutTake;  // open access ran out of time
    logic [MBT_SLOT_W-1:0] slot;      // slot of the open access
  } ctlStrb_t;

endpackage

// File: rtl/mbt_sync.sv
module mbt_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= {WIDTH{RST_VAL}};
      stage2 <= {WIDTH{RST_VAL}};
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;

endmodule

// File: rtl/mbt_ctrl.sv
module mbt_ctrl
  import mbt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 400
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accStart,
  input  logic [MBT_SLOT_W-1:0] accSlot,
  input  logic                  modAck,
  output ctlStrb_t              strb
);

  localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  mbtState_t             state;
  logic [CNT_W-1:0]      waitCnt;
  logic [MBT_SLOT_W-1:0] slotQ;
  logic                  windowEnd;
  logic                  open;

  assign open      = (state == ST_WAIT);
  assign windowEnd = (waitCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      slotQ   <= '0;
    end else if (accStart) begin
      // a new access always restarts the window, abandoning an open one
      state   <= ST_WAIT;
      waitCnt <= '0;
      slotQ   <= accSlot;
    end else if (open) begin
      if (modAck || windowEnd) begin
        state   <= ST_IDLE;
        waitCnt <= '0;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.ackTake  = open & modAck & ~accStart;
    strb.toutTake = open & ~modAck & windowEnd & ~accStart;
    strb.slot     = slotQ;
  end

endmodule

// File: rtl/mbt_dpath.sv
module mbt_dpath
  import mbt_pkg::*;
#(
  parameter  int unsigned DATA_W       = 16,
  parameter  int unsigned IRQ_PER_SLOT = 2,
  localparam int unsigned IRQ_W        = MBT_SLOTS * IRQ_PER_SLOT,
  localparam int unsigned CLR_W        = IRQ_W + MBT_SLOTS,
  localparam int unsigned STAT_W       = IRQ_W + 2 * MBT_SLOTS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrb_t             strb,
  input  logic [DATA_W-1:0]    modRdata,
  input  logic                 regWe,
  input  logic [CLR_W-1:0]     regWdata,
  input  logic [MBT_SLOTS-1:0] toutEn,
  input  logic [IRQ_W-1:0]     edgeMode,
  input  logic [IRQ_W-1:0]     slotIrqN,
  input  logic [MBT_SLOTS-1:0] slotErrN,
  output logic                 hostDone,
  output logic [DATA_W-1:0]    hostRdata,
  output logic [STAT_W-1:0]    statusOut,
  output logic                 irqReq
);

  logic [IRQ_W-1:0]     irqSyncN;
  logic [MBT_SLOTS-1:0] errSyncN;
  logic [IRQ_W-1:0]     irqAct;
  logic [IRQ_W-1:0]     irqActQ;
  logic [IRQ_W-1:0]     intStat;
  logic [IRQ_W-1:0]     clrInt;
  logic [MBT_SLOTS-1:0] clrTout;
  logic [MBT_SLOTS-1:0] setTout;
  logic [MBT_SLOTS-1:0] toutFlag;

  mbt_sync #(.WIDTH(IRQ_W), .RST_VAL(1'b1)) u_irqSync (
    .clk (clk),
    .rstN(rstN),
    .din (slotIrqN),
    .dout(irqSyncN)
  );

  mbt_sync #(.WIDTH(MBT_SLOTS), .RST_VAL(1'b1)) u_errSync (
    .clk (clk),
    .rstN(rstN),
    .din (slotErrN),
    .dout(errSyncN)
  );

  assign irqAct  = ~irqSyncN;
  assign clrInt  = regWe ? regWdata[IRQ_W-1:0] : '0;
  assign clrTout = regWe ? regWdata[IRQ_W +: MBT_SLOTS] : '0;
  assign setTout = strb.toutTake ? (MBT_SLOTS'(1) << strb.slot) : '0;

  // previous synchronized level, for activation detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqActQ <= '0;
    else       irqActQ <= irqAct;
  end

  // one status bit per interrupt line, mode chosen per line
  for (genvar g = 0; g < IRQ_W; g++) begin : g_line
    logic bitQ;
    logic rise;
    assign rise = irqAct[g] & ~irqActQ[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            bitQ <= 1'b0;
      else if (edgeMode[g]) bitQ <= rise | (bitQ & ~clrInt[g]);
      else                  bitQ <= irqAct[g];
    end
    assign intStat[g] = bitQ;
  end

  // sticky timeout flags, a set beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) toutFlag <= '0;
    else       toutFlag <= setTout | (toutFlag & ~clrTout);
  end

  // completion toward the host
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostDone  <= 1'b0;
      hostRdata <= '0;
    end else begin
      hostDone <= strb.ackTake | strb.toutTake;
      if (strb.toutTake)     hostRdata <= '1;
      else if (strb.ackTake) hostRdata <= modRdata;
    end
  end

  assign irqReq    = |(toutFlag & toutEn);
  assign statusOut = {~errSyncN, toutFlag, intStat};

endmodule

// File: rtl/mbt_top.sv
module mbt_top
  import mbt_pkg::*;
#(
  parameter  int unsigned CLK_HZ         = 50_000_000,
  parameter  int unsigned TIMEOUT_CYCLES = CLK_HZ / 125_000,
  parameter  int unsigned DATA_W         = 16,
  parameter  int unsigned IRQ_PER_SLOT   = 2,
  localparam int unsigned IRQ_W          = MBT_SLOTS * IRQ_PER_SLOT,
  localparam int unsigned CLR_W          = IRQ_W + MBT_SLOTS,
  localparam int unsigned STAT_W         = IRQ_W + 2 * MBT_SLOTS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accStart,
  input  logic [MBT_SLOT_W-1:0] accSlot,
  input  logic                  modAck,
  input  logic [DATA_W-1:0]     modRdata,
  output logic                  hostDone,
  output logic [DATA_W-1:0]     hostRdata,
  input  logic                  regWe,
  input  logic [CLR_W-1:0]      regWdata,
  output logic [STAT_W-1:0]     statusOut,
  input  logic [MBT_SLOTS-1:0]  toutEn,
  input  logic [IRQ_W-1:0]      edgeMode,
  input  logic [IRQ_W-1:0]      slotIrqN,
  input  logic [MBT_SLOTS-1:0]  slotErrN,
  output logic                  irqReq
);

  ctlStrb_t strb;

  mbt_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .accStart(accStart),
    .accSlot (accSlot),
    .modAck  (modAck),
    .strb    (strb)
  );

  mbt_dpath #(.DATA_W(DATA_W), .IRQ_PER_SLOT(IRQ_PER_SLOT)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modRdata (modRdata),
    .regWe    (regWe),
    .regWdata (regWdata),
    .toutEn   (toutEn),
    .edgeMode (edgeMode),
    .slotIrqN (slotIrqN),
    .slotErrN (slotErrN),
    .hostDone (hostDone),
    .hostRdata(hostRdata),
    .statusOut(statusOut),
    .irqReq   (irqReq)
  );

endmodule

// File: rtl/mbt_checker.sv
module mbt_checker
  import mbt_pkg::*;
#(
  parameter  int unsigned DATA_W       = 16,
  parameter  int unsigned IRQ_PER_SLOT = 2,
  localparam int unsigned IRQ_W        = MBT_SLOTS * IRQ_PER_SLOT,
  localparam int unsigned STAT_W       = IRQ_W + 2 * MBT_SLOTS
) (
  input logic                 clk,
  input logic                 rstN,
  input ctlStrb_t             strb,
  input logic                 hostDone,
  input logic [DATA_W-1:0]    hostRdata,
  input logic [DATA_W-1:0]    modRdata,
  input logic [STAT_W-1:0]    statusOut,
  input logic [MBT_SLOTS-1:0] toutEn,
  input logic                 irqReq,
  input logic [MBT_SLOTS-1:0] slotErrN,
  input logic [IRQ_W-1:0]     slotIrqN,
  input logic [IRQ_W-1:0]     edgeMode
);

  logic [1:0]           settleCnt;
  logic                 settled;
  logic [MBT_SLOTS-1:0] slotMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  settleCnt <= '0;
    else if (settleCnt != 2'd3) settleCnt <= settleCnt + 2'd1;
  end

  assign settled  = (settleCnt == 2'd3);
  assign slotMask = MBT_SLOTS'(1) << strb.slot;

  a_r1_ack_completes: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> (hostDone && hostRdata == $past(modRdata)));

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.ackTake && strb.toutTake));

  a_r2_timeout_ones: assert property (@(posedge clk) disable iff (!rstN)
    strb.toutTake |=> (hostDone && hostRdata == {DATA_W{1'b1}} &&
                       ((statusOut[IRQ_W +: MBT_SLOTS] & $past(slotMask)) != '0)));

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    (toutEn == '0) |-> !irqReq);

  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (statusOut[IRQ_W +: MBT_SLOTS] != '0));

  a_r6_err_direct: assert property (@(posedge clk) disable iff (!rstN)
    settled |-> (statusOut[IRQ_W + MBT_SLOTS +: MBT_SLOTS] == ~$past(slotErrN, 2)));

  for (genvar g = 0; g < IRQ_W; g++) begin : g_lvl
    a_r8_level_follow: assert property (@(posedge clk) disable iff (!rstN)
      (settled && !$past(edgeMode[g])) |-> (statusOut[g] == ~$past(slotIrqN[g], 3)));
  end

endmodule

bind mbt_top mbt_checker #(.DATA_W(DATA_W), .IRQ_PER_SLOT(IRQ_PER_SLOT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .hostDone (hostDone),
  .hostRdata(hostRdata),
  .modRdata (modRdata),
  .statusOut(statusOut),
  .toutEn   (toutEn),
  .irqReq   (irqReq),
  .slotErrN (slotErrN),
  .slotIrqN (slotIrqN),
  .edgeMode (edgeMode)
);

// File: tb/mbt_top_tb.sv
module mbt_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2_000_000;
  localparam int TOUT       = CLK_HZ / 125_000;
  localparam int NS         = 4;
  localparam int IRQ_W      = 8;
  localparam int CLR_W      = 12;
  localparam int STAT_W     = 16;
  localparam int DW         = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accStart = 1'b0;
  logic [1:0]        accSlot = '0;
  logic              modAck = 1'b0;
  logic [DW-1:0]     modRdata = '0;
  logic              hostDone;
  logic [DW-1:0]     hostRdata;
  logic              regWe = 1'b0;
  logic [CLR_W-1:0]  regWdata = '0;
  logic [STAT_W-1:0] statusOut;
  logic [NS-1:0]     toutEn = '0;
  logic [IRQ_W-1:0]  edgeMode = '0;
  logic [IRQ_W-1:0]  slotIrqN = '1;
  logic [NS-1:0]     slotErrN = '1;
  logic              irqReq;

  int            checks = 0;
  int            failures = 0;
  logic [NS-1:0] expFlags = '0;

  mbt_top #(.CLK_HZ(CLK_HZ), .DATA_W(DW), .IRQ_PER_SLOT(2)) u_dut (
    .clk(clk), .rstN(rstN), .accStart(accStart), .accSlot(accSlot),
    .modAck(modAck), .modRdata(modRdata), .hostDone(hostDone),
    .hostRdata(hostRdata), .regWe(regWe), .regWdata(regWdata),
    .statusOut(statusOut), .toutEn(toutEn), .edgeMode(edgeMode),
    .slotIrqN(slotIrqN), .slotErrN(slotErrN), .irqReq(irqReq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin : watchdog
    repeat (100_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // cycle after the start at which hostDone is expected
  function automatic int expDoneAt(input int ackDelay);
    return (ackDelay <= TOUT - 1) ? ackDelay + 1 : TOUT;
  endfunction

  function automatic logic [DW-1:0] expData(input int ackDelay, input logic [DW-1:0] d);
    return (ackDelay <= TOUT - 1) ? d : '1;
  endfunction

  task automatic clearWrite(input logic [CLR_W-1:0] mask);
    regWe = 1'b1;
    regWdata = mask;
    tick();
    regWe = 1'b0;
    regWdata = '0;
  endtask

  // open an access and follow it until completion; optional clear write at clrAt
  task automatic runAccess(input int slot, input int ackDelay, input logic [DW-1:0] data,
                           input int clrAt, input logic [CLR_W-1:0] clrMask,
                           output int doneAt, output logic [DW-1:0] got);
    int k;
    accStart = 1'b1;
    accSlot = 2'(slot);
    modRdata = data;
    tick();
    accStart = 1'b0;
    k = 0;
    doneAt = -1;
    got = '0;
    while (k <= TOUT + 5) begin
      modAck = (k == ackDelay);
      regWe = (k == clrAt);
      regWdata = (k == clrAt) ? clrMask : '0;
      tick();
      k++;
      regWe = 1'b0;
      regWdata = '0;
      if (hostDone) begin
        doneAt = k;
        got = hostRdata;
        break;
      end
    end
    modAck = 1'b0;
  endtask

  task automatic checkAccess(input string req, input int slot, input int ackDelay,
                             input logic [DW-1:0] data);
    int doneAt;
    logic [DW-1:0] got;
    runAccess(slot, ackDelay, data, -1, '0, doneAt, got);
    if (ackDelay > TOUT - 1) expFlags[slot] = 1'b1;
    check(doneAt == expDoneAt(ackDelay), req, "completion cycle", doneAt, expDoneAt(ackDelay));
    check(got == expData(ackDelay, data), req, "completion data", got, expData(ackDelay, data));
    tick();
    check(hostDone == 1'b0, "R1", "done pulse width", hostDone, 0);
    check(statusOut[11:8] == expFlags, req, "timeout flags", statusOut[11:8], expFlags);
  endtask

  initial begin : main
    int doneAt;
    logic [DW-1:0] got;
    logic [CLR_W-1:0] m;
    void'($urandom(32'h1A2B3C));

    repeat (3) tick();
    rstN = 1'b1;
    check(hostDone == 1'b0, "R10", "hostDone after reset", hostDone, 0);
    check(statusOut == '0, "R10", "status after reset", statusOut, 0);
    check(irqReq == 1'b0, "R10", "irqReq after reset", irqReq, 0);

    // R1 / R2 directed window boundaries
    checkAccess("R1", 0, 0, 16'h1234);
    checkAccess("R1", 1, TOUT - 1, 16'hBEEF);
    checkAccess("R2", 2, TOUT, 16'h5555);
    checkAccess("R2", 3, 1000, 16'h0F0F);

    // R5 enable gating
    toutEn = 4'b0000;
    #1 check(irqReq == 1'b0, "R5", "irq with no enable", irqReq, 0);
    toutEn = 4'b0100;
    #1 check(irqReq == 1'b1, "R5", "irq with slot2 enable", irqReq, 1);
    toutEn = 4'b0011;
    #1 check(irqReq == 1'b0, "R5", "irq enable on clean slots", irqReq, 0);

    // R4 write-zero has no effect, write-one clears
    clearWrite('0);
    check(statusOut[11:8] == expFlags, "R4", "zero write keeps flags", statusOut[11:8], expFlags);
    clearWrite(12'h400);
    expFlags[2] = 1'b0;
    check(statusOut[11:8] == expFlags, "R4", "clear slot2 flag", statusOut[11:8], expFlags);

    // R4 set wins: slot3 flag already set, clear it in the expiring cycle
    runAccess(3, 1000, 16'h0, TOUT - 1, 12'h800, doneAt, got);
    check(doneAt == TOUT, "R2", "timeout cycle under clear", doneAt, TOUT);
    tick();
    check(statusOut[11] == 1'b1, "R4", "set beats clear", statusOut[11], 1);

    // R3 restart abandons the previous access
    clearWrite(12'hF00);
    expFlags = '0;
    accStart = 1'b1; accSlot = 2'd1; tick(); accStart = 1'b0;
    got = '0;
    for (int i = 0; i < TOUT - 4; i++) begin
      tick();
      if (hostDone) got = 16'h1;
    end
    runAccess(2, 1000, 16'h0, -1, '0, doneAt, got);
    check(doneAt == TOUT, "R3", "restarted window length", doneAt, TOUT);
    tick();
    check(statusOut[11:8] == 4'b0100, "R3", "only new slot flagged", statusOut[11:8], 4'b0100);
    expFlags = 4'b0100;

    // random accesses across the window boundary
    for (int n = 0; n < 40; n++) begin
      int s;
      int d;
      s = int'($urandom_range(0, NS - 1));
      d = int'($urandom_range(0, TOUT + 3));
      checkAccess(d > TOUT - 1 ? "R2" : "R1", s, d, 16'($urandom));
      toutEn = 4'($urandom);
      #1 check(irqReq == |(expFlags & toutEn), "R5", "random irq", irqReq, |(expFlags & toutEn));
      if ($urandom_range(0, 3) == 0) begin
        m = {4'($urandom), 8'h00};
        clearWrite(m);
        expFlags &= ~m[11:8];
        check(statusOut[11:8] == expFlags, "R4", "random clear", statusOut[11:8], expFlags);
      end
    end

    // R6 error lines follow without latching
    slotErrN = 4'b1010;
    tick(); tick();
    check(statusOut[15:12] == 4'b0101, "R6", "error asserted", statusOut[15:12], 4'b0101);
    slotErrN = 4'b1111;
    tick(); tick();
    check(statusOut[15:12] == 4'b0000, "R6", "error released", statusOut[15:12], 0);

    // R7 edge capture
    edgeMode = 8'hFF;
    tick();
    slotIrqN[2] = 1'b0;
    repeat (3) tick();
    check(statusOut[2] == 1'b1, "R7", "edge captured", statusOut[2], 1);
    slotIrqN[2] = 1'b1;
    repeat (3) tick();
    check(statusOut[2] == 1'b1, "R7", "edge held", statusOut[2], 1);
    clearWrite(12'h0);
    check(statusOut[2] == 1'b1, "R7", "zero write keeps edge", statusOut[2], 1);
    clearWrite(12'h004);
    check(statusOut[2] == 1'b0, "R7", "edge cleared", statusOut[2], 0);

    // R9 activation and clear in the same cycle
    slotIrqN[5] = 1'b0; repeat (3) tick();
    slotIrqN[5] = 1'b1; repeat (3) tick();
    check(statusOut[5] == 1'b1, "R9", "edge primed", statusOut[5], 1);
    slotIrqN[5] = 1'b0;
    tick(); tick();
    clearWrite(12'h020);
    check(statusOut[5] == 1'b1, "R9", "activation beats clear", statusOut[5], 1);
    slotIrqN[5] = 1'b1;
    repeat (3) tick();
    clearWrite(12'h020);
    check(statusOut[5] == 1'b0, "R9", "later clear works", statusOut[5], 0);

    // R8 level mode
    edgeMode = 8'h00;
    slotIrqN[6] = 1'b0;
    repeat (3) tick();
    check(statusOut[6] == 1'b1, "R8", "level active", statusOut[6], 1);
    clearWrite(12'h040);
    check(statusOut[6] == 1'b1, "R8", "write ignored", statusOut[6], 1);
    slotIrqN[6] = 1'b1;
    repeat (3) tick();
    check(statusOut[6] == 1'b0, "R8", "level released", statusOut[6], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule